// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath with Guarded Accumulators

This block is the arithmetic core of a 24-bit fixed-point signal processor. Four 24-bit operand registers feed a signed fractional multiplier. The operand registers are named X0, X1, Y0 and Y1, and they also read as the 48-bit pairs X = X1:X0 and Y = Y1:Y0. The multiplier result lands in one of two 56-bit accumulators, A or B. Each accumulator is an 8-bit guard field on top of a 24-bit high word and a 24-bit low word. An opcode presented in a cycle selects one operation, and the destination accumulator takes the result at the next rising clock edge. There is no pipeline.

The operations are a plain multiply, multiply-accumulate and accumulator addition. Each of these can subtract instead of add, and each can optionally round to nearest-even at a bit chosen by a scaling input. There are also four 24-bit bitwise operations that touch only the high word of the destination. The operand registers are written through a single write port and can be read back as words or as pairs.

Top module: `fmac_dp`

## Requirements
- R1: While rst_n is low, and after it is released, all four operand registers and both accumulators read zero.
- R2: A write with wr_en=1 stores wr_data into the register picked by wr_sel (0=X0, 1=X1, 2=Y0, 3=Y1) at the clock edge. rd_word returns the register picked by rd_sel. rd_pair returns X1:X0 when pair_sel=0 and Y1:Y0 when pair_sel=1.
- R3: op=1 (multiply) loads the destination with the product of the registers picked by src_a and src_b, read as signed 1.23 fractions. The product is doubled, sign-extended to 56 bits, and negated when acc_sub=1. Its guard byte is therefore all zeros or all ones.
- R4: op=2 (multiply-accumulate) adds the same product to the full 56-bit destination, or subtracts it when acc_sub=1. The result wraps modulo 2^56.
- R5: Sums that grow past magnitude 1.0 are carried into the 8-bit guard field without loss. For example, four multiplies of -1.0 by -1.0 give 0x02_000000_000000.
- R6: op=3 adds to the destination, or subtracts from it when acc_sub=1, an addend picked by add_src. The choices are the other accumulator (add_src 0 or 3), the X pair (1) or the Y pair (2). Each pair is sign-extended from bit 47.
- R7: With rnd_en=1 on ops 1 to 3, the result is rounded at position p and every bit at or below p is cleared. Here p=23 for scale 00 or 11, p=24 for scale 01 (down-scaled) and p=22 for scale 10 (up-scaled).
- R8: When the bits at and below p are exactly 1 followed by zeros, the rounded result keeps an even value at bit p+1.
- R9: Ops 4 to 7 (AND, OR, XOR with the src_a register, and complement) replace only bits 47:24 of the destination. The guard and low fields stay unchanged. The complement ignores src_a.
- R10: When a register is written in the same cycle that it serves as an operand, the operation uses the value it held before the write.
- R11: The accumulator not picked by dst_sel keeps its value. op=0 changes neither accumulator. rnd_en and acc_sub have no effect on ops 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Operand register write strobe |
| wr_sel | input | 2 | Register to write (0=X0,1=X1,2=Y0,3=Y1) |
| wr_data | input | 24 | Write data |
| op | input | 3 | Operation code (0 none, 1 mpy, 2 mac, 3 add, 4 and, 5 or, 6 xor, 7 not) |
| acc_sub | input | 1 | Subtract rather than add on ops 1-3 |
| rnd_en | input | 1 | Convergent rounding on ops 1-3 |
| scale | input | 2 | Scaling mode that picks the rounding bit |
| src_a | input | 2 | First multiplier/logic operand register |
| src_b | input | 2 | Second multiplier operand register |
| add_src | input | 2 | Addend for op 3 |
| dst_sel | input | 1 | Destination accumulator (0=A, 1=B) |
| rd_sel | input | 2 | Register shown on rd_word |
| rd_word | output | 24 | Operand register readback |
| pair_sel | input | 1 | Pair shown on rd_pair (0=X, 1=Y) |
| rd_pair | output | 48 | 48-bit pair readback |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |

## Verification
Two things can land in one clock edge: an operand register write and an arithmetic operation that reads the same register. Rounding ties can also coincide with a carry that travels into the guard byte. The random stimulus often aims the write port at src_a or src_b, or at the pair chosen by add_src. Every such cycle is compared against a reference model that evaluates the operation on the registers as they stood before the write. The directed cases build exact halfway values through the X pair at every scaling mode. They also stack products of -1.0 by -1.0 past 1.0, and the bench judges the guard byte and the even retained bit that result.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_MPY  = 3'd1,
    OP_MAC  = 3'd2,
    OP_ADD  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_NOT  = 3'd7
  } mac_op_e;

  typedef enum logic [1:0] {
    SC_NONE = 2'b00,
    SC_DOWN = 2'b01,
    SC_UP   = 2'b10,
    SC_RSVD = 2'b11
  } scale_e;

  typedef enum logic [1:0] {
    ADD_OTHER = 2'd0,
    ADD_XPAIR = 2'd1,
    ADD_YPAIR = 2'd2,
    ADD_OTH2  = 2'd3
  } add_src_e;
endpackage

// File: rtl/fmac_inregs.sv
module fmac_inregs #(
  parameter int DW   = 24,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SW-1:0]            wr_sel,
  input  logic [DW-1:0]            wr_data,
  output logic [NREG-1:0][DW-1:0]  regs_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[i] <= '0;
      else if (wr_en && (wr_sel == SW'(i)))
        regs_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/fmac_arith.sv
module fmac_arith
  import fmac_pkg::*;
#(
  parameter int DW  = 24,
  parameter int GW  = 8,
  localparam int PW = 2 * DW,
  localparam int AW = PW + GW
) (
  input  mac_op_e        op,
  input  logic           acc_sub,
  input  logic           rnd_en,
  input  logic [1:0]     scale,
  input  logic [DW-1:0]  opnd_a,
  input  logic [DW-1:0]  opnd_b,
  input  logic [1:0]     add_src,
  input  logic [PW-1:0]  x_pair,
  input  logic [PW-1:0]  y_pair,
  input  logic [AW-1:0]  acc_dst,
  input  logic [AW-1:0]  acc_oth,
  output logic [AW-1:0]  acc_nxt,
  output logic           acc_we,
  output logic           mpy_fire,
  output logic           rnd_fire,
  output logic           tie_hit,
  output logic           log_fire
);
  // Signed 1.23 x 1.23 product, doubled to 1.47 and sign-extended to AW
  function automatic logic [AW-1:0] frac_prod(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [PW-1:0] p;
    logic [AW-1:0] ext;
    p   = $signed(a) * $signed(b);
    ext = {{GW{p[PW-1]}}, p};
    return ext << 1;
  endfunction

  function automatic logic [AW-1:0] pair_ext(input logic [PW-1:0] v);
    return {{GW{v[PW-1]}}, v};
  endfunction

  // One-hot weight of the half-LSB added by rounding
  function automatic logic [AW-1:0] half_bit(input logic [1:0] sc);
    case (sc)
      SC_DOWN: return AW'(1) << DW;
      SC_UP:   return AW'(1) << (DW - 2);
      default: return AW'(1) << (DW - 1);
    endcase
  endfunction

  function automatic logic is_tie(input logic [AW-1:0] v, input logic [1:0] sc);
    logic [AW-1:0] h;
    h = half_bit(sc);
    return (v & ((h << 1) - AW'(1))) == h;
  endfunction

  function automatic logic [AW-1:0] conv_round(input logic [AW-1:0] v, input logic [1:0] sc);
    logic [AW-1:0] h, keep, low, s;
    h    = half_bit(sc);
    keep = h << 1;
    low  = keep - AW'(1);
    s    = v + h;
    if (is_tie(v, sc)) s = s & ~keep;
    return s & ~low;
  endfunction

  logic [AW-1:0] prod, base, addend, sum, arith_res;
  logic [DW-1:0] msp_new;
  logic          is_arith, is_logic;

  assign is_arith = (op == OP_MPY) || (op == OP_MAC) || (op == OP_ADD);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOT);
  assign prod     = frac_prod(opnd_a, opnd_b);

  always_comb begin
    base = (op == OP_MPY) ? '0 : acc_dst;
    if (op == OP_ADD) begin
      case (add_src)
        ADD_XPAIR: addend = pair_ext(x_pair);
        ADD_YPAIR: addend = pair_ext(y_pair);
        default:   addend = acc_oth;
      endcase
    end else begin
      addend = prod;
    end
  end

  assign sum       = acc_sub ? (base - addend) : (base + addend);
  assign arith_res = rnd_en ? conv_round(sum, scale) : sum;

  always_comb begin
    case (op)
      OP_AND:  msp_new = acc_dst[PW-1:DW] & opnd_a;
      OP_OR:   msp_new = acc_dst[PW-1:DW] | opnd_a;
      OP_XOR:  msp_new = acc_dst[PW-1:DW] ^ opnd_a;
      default: msp_new = ~acc_dst[PW-1:DW];
    endcase
  end

  always_comb begin
    if (is_logic)      acc_nxt = {acc_dst[AW-1:PW], msp_new, acc_dst[DW-1:0]};
    else if (is_arith) acc_nxt = arith_res;
    else               acc_nxt = acc_dst;
  end

  assign acc_we   = is_arith || is_logic;
  assign mpy_fire = (op == OP_MPY);
  assign rnd_fire = is_arith && rnd_en;
  assign tie_hit  = rnd_fire && is_tie(sum, scale);
  assign log_fire = is_logic;
endmodule

// File: rtl/fmac_dp.sv
module fmac_dp
  import fmac_pkg::*;
#(
  parameter int DW   = 24,
  parameter int GW   = 8,
  parameter int NREG = 4,
  localparam int PW  = 2 * DW,
  localparam int AW  = PW + GW,
  localparam int SW  = $clog2(NREG),
  localparam int NACC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_sel,
  input  logic [DW-1:0]  wr_data,
  input  logic [2:0]     op,
  input  logic           acc_sub,
  input  logic           rnd_en,
  input  logic [1:0]     scale,
  input  logic [SW-1:0]  src_a,
  input  logic [SW-1:0]  src_b,
  input  logic [1:0]     add_src,
  input  logic           dst_sel,
  input  logic [SW-1:0]  rd_sel,
  output logic [DW-1:0]  rd_word,
  input  logic           pair_sel,
  output logic [PW-1:0]  rd_pair,
  output logic [AW-1:0]  acc_a,
  output logic [AW-1:0]  acc_b
);
  logic [NREG-1:0][DW-1:0] regs_q;
  logic [NACC-1:0][AW-1:0] acc_q;
  logic [PW-1:0] x_pair, y_pair;
  logic [AW-1:0] acc_nxt;
  logic          acc_we;
  // Named internal events observed by the checker
  logic          mpy_fire, rnd_fire, tie_hit, log_fire;

  fmac_inregs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .regs_q  (regs_q)
  );

  assign x_pair = {regs_q[1], regs_q[0]};
  assign y_pair = {regs_q[3], regs_q[2]};

  fmac_arith #(.DW(DW), .GW(GW)) u_arith (
    .op       (mac_op_e'(op)),
    .acc_sub  (acc_sub),
    .rnd_en   (rnd_en),
    .scale    (scale),
    .opnd_a   (regs_q[src_a]),
    .opnd_b   (regs_q[src_b]),
    .add_src  (add_src),
    .x_pair   (x_pair),
    .y_pair   (y_pair),
    .acc_dst  (acc_q[dst_sel]),
    .acc_oth  (acc_q[~dst_sel]),
    .acc_nxt  (acc_nxt),
    .acc_we   (acc_we),
    .mpy_fire (mpy_fire),
    .rnd_fire (rnd_fire),
    .tie_hit  (tie_hit),
    .log_fire (log_fire)
  );

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rst_n)
        acc_q[i] <= '0;
      else if (acc_we && (dst_sel == 1'(i)))
        acc_q[i] <= acc_nxt;
    end
  end

  assign acc_a   = acc_q[0];
  assign acc_b   = acc_q[1];
  assign rd_word = regs_q[rd_sel];
  assign rd_pair = pair_sel ? y_pair : x_pair;
endmodule

// File: rtl/fmac_chk.sv
module fmac_chk #(
  parameter int DW  = 24,
  parameter int AW  = 56
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op,
  input logic          dst_sel,
  input logic [1:0]    scale,
  input logic [AW-1:0] acc_a,
  input logic [AW-1:0] acc_b,
  input logic          mpy_fire,
  input logic          rnd_fire,
  input logic          tie_hit,
  input logic          log_fire
);
  localparam int PW = 2 * DW;

  logic [AW-1:0] low_mask, even_mask;
  always_comb begin
    case (scale)
      2'b01:   low_mask = (AW'(1) << (DW + 1)) - AW'(1);
      2'b10:   low_mask = (AW'(1) << (DW - 1)) - AW'(1);
      default: low_mask = (AW'(1) << DW) - AW'(1);
    endcase
    even_mask = (low_mask << 1) | AW'(1);
  end

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0) |=> (acc_a == $past(acc_a)) && (acc_b == $past(acc_b)));

  // R11
  other_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_sel |=> acc_a == $past(acc_a));

  // R11
  other_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_sel |=> acc_b == $past(acc_b));

  // R3
  mpy_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mpy_fire |=> ($past(dst_sel) ? (acc_b[AW-1:PW] == '0 || acc_b[AW-1:PW] == '1)
                                 : (acc_a[AW-1:PW] == '0 || acc_a[AW-1:PW] == '1)));

  // R9
  logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_fire |=> ($past(dst_sel)
      ? (acc_b[AW-1:PW] == $past(acc_b[AW-1:PW]) && acc_b[DW-1:0] == $past(acc_b[DW-1:0]))
      : (acc_a[AW-1:PW] == $past(acc_a[AW-1:PW]) && acc_a[DW-1:0] == $past(acc_a[DW-1:0]))));

  // R7
  rnd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_fire |=> ((($past(dst_sel) ? acc_b : acc_a) & $past(low_mask)) == '0));

  // R8
  tie_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tie_hit |=> ((($past(dst_sel) ? acc_b : acc_a) & $past(even_mask)) == '0));
endmodule

bind fmac_dp fmac_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op       (op),
  .dst_sel  (dst_sel),
  .scale    (scale),
  .acc_a    (acc_a),
  .acc_b    (acc_b),
  .mpy_fire (mpy_fire),
  .rnd_fire (rnd_fire),
  .tie_hit  (tie_hit),
  .log_fire (log_fire)
);

// File: tb/sim_fmac_dp.sv
`timescale 1ns/1ps
module sim_fmac_dp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [23:0] wr_data = '0;
  logic [2:0]  op = '0;
  logic        acc_sub = 1'b0, rnd_en = 1'b0, dst_sel = 1'b0, pair_sel = 1'b0;
  logic [1:0]  scale = '0, src_a = '0, src_b = '0, add_src = '0, rd_sel = '0;
  logic [23:0] rd_word;
  logic [47:0] rd_pair;
  logic [55:0] acc_a, acc_b;

  int n_chk = 0, n_bad = 0;
  logic [23:0] m_x [4];
  logic [55:0] m_acc [2];

  always #5 clk = ~clk;

  fmac_dp u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .op(op), .acc_sub(acc_sub), .rnd_en(rnd_en), .scale(scale), .src_a(src_a),
    .src_b(src_b), .add_src(add_src), .dst_sel(dst_sel), .rd_sel(rd_sel),
    .rd_word(rd_word), .pair_sel(pair_sel), .rd_pair(rd_pair),
    .acc_a(acc_a), .acc_b(acc_b)
  );

  task automatic check(input string tag, input logic [55:0] act, input logic [55:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %014h expected %014h", tag, act, exp);
    end
  endtask

  function automatic longint s24(input logic [23:0] v);
    return longint'($signed(v));
  endfunction
  function automatic longint s48(input logic [47:0] v);
    return longint'($signed(v));
  endfunction
  function automatic longint s56(input logic [55:0] v);
    return longint'($signed({{8{v[55]}}, v}));
  endfunction

  // Rounding by integer division: keep floor quotient, bump on > half or odd tie
  function automatic logic [55:0] m_round(input logic [55:0] v, input logic [1:0] sc);
    int p;
    longint sv, q, step, rem, half;
    logic [63:0] r;
    p = (sc == 2'b01) ? 24 : (sc == 2'b10) ? 22 : 23;
    step = longint'(1) <<< (p + 1);
    half = longint'(1) <<< p;
    sv   = s56(v);
    q    = sv >>> (p + 1);
    rem  = sv - q * step;
    if (rem > half || (rem == half && q[0])) q = q + 1;
    r = 64'(q * step);
    return r[55:0];
  endfunction

  function automatic logic [55:0] m_alu(input logic [2:0] o, input logic s, input logic r,
      input logic [1:0] sc, input logic [1:0] sa, input logic [1:0] sb,
      input logic [1:0] as, input logic d);
    logic [55:0] dst, oth, res;
    logic [23:0] mid;
    longint base, add;
    logic [63:0] t;
    dst = m_acc[d];
    oth = m_acc[!d];
    if (o == 3'd0) return dst;
    if (o >= 3'd4) begin
      case (o)
        3'd4:    mid = dst[47:24] & m_x[sa];
        3'd5:    mid = dst[47:24] | m_x[sa];
        3'd6:    mid = dst[47:24] ^ m_x[sa];
        default: mid = ~dst[47:24];
      endcase
      return {dst[55:48], mid, dst[23:0]};
    end
    if (o == 3'd3) begin
      add  = (as == 2'd1) ? s48({m_x[1], m_x[0]}) :
             (as == 2'd2) ? s48({m_x[3], m_x[2]}) : s56(oth);
      base = s56(dst);
    end else begin
      add  = s24(m_x[sa]) * s24(m_x[sb]) * 2;
      base = (o == 3'd1) ? 0 : s56(dst);
    end
    t   = 64'(s ? base - add : base + add);
    res = t[55:0];
    return r ? m_round(res, sc) : res;
  endfunction

  task automatic vec(input string tag, input logic [2:0] o, input logic s, input logic r,
      input logic [1:0] sc, input logic [1:0] sa, input logic [1:0] sb,
      input logic [1:0] as, input logic d, input logic we, input logic [1:0] ws,
      input logic [23:0] wd);
    logic [55:0] nxt;
    op = o; acc_sub = s; rnd_en = r; scale = sc; src_a = sa; src_b = sb;
    add_src = as; dst_sel = d; wr_en = we; wr_sel = ws; wr_data = wd;
    rd_sel = 2'($urandom_range(0, 3)); pair_sel = 1'($urandom_range(0, 1));
    nxt = m_alu(o, s, r, sc, sa, sb, as, d);   // R10: uses pre-write registers
    @(posedge clk);
    @(negedge clk);
    if (o != 3'd0) m_acc[d] = nxt;
    if (we) m_x[ws] = wd;
    wr_en = 1'b0;
    check({tag, " acc_a"}, acc_a, m_acc[0]);
    check({tag, " acc_b"}, acc_b, m_acc[1]);
    check("R2 rd_word", {32'd0, rd_word}, {32'd0, m_x[rd_sel]});
    check("R2 rd_pair", {8'd0, rd_pair},
          {8'd0, pair_sel ? {m_x[3], m_x[2]} : {m_x[1], m_x[0]}});
  endtask

  task automatic wr(input logic [1:0] ws, input logic [23:0] wd);
    vec("R2 write", 3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, ws, wd);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 4; i++) m_x[i] = '0;
    m_acc[0] = '0; m_acc[1] = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 acc_a in reset", acc_a, '0);
    check("R1 acc_b in reset", acc_b, '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i);
      #1 check("R1 reg after reset", {32'd0, rd_word}, '0);
    end

    // R2 loads, then R3 -1.0 * -1.0 = +1.0 with zero guard byte
    wr(2'd0, 24'h800000); wr(2'd1, 24'h800000); wr(2'd2, 24'h400000); wr(2'd3, 24'h000000);
    vec("R3 mpy -1*-1", 3'd1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 2'd0, 24'd0);
    check("R3 mpy value", acc_a, 56'h00_800000_000000);
    // R5: stack three more into the guard field
    for (int k = 0; k < 3; k++)
      vec("R5 mac grow", 3'd2, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 2'd0, 24'd0);
    check("R5 guard carry", acc_a, 56'h02_000000_000000);
    // R3 negated multiply into B, R4 subtracting accumulate
    vec("R3 mpy neg", 3'd1, 1'b1, 1'b0, 2'd0, 2'd2, 2'd2, 2'd0, 1'b1, 1'b0, 2'd0, 24'd0);
    check("R3 neg value", acc_b, 56'hFF_E00000_000000);
    vec("R4 mac sub", 3'd2, 1'b1, 1'b0, 2'd0, 2'd2, 2'd2, 2'd0, 1'b1, 1'b0, 2'd0, 24'd0);
    // R6 add other accumulator
    vec("R6 add other", 3'd3, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 24'd0);

    // R7/R8 ties built through the X pair at each scale
    for (int sc = 0; sc < 4; sc++) begin
      for (int odd = 0; odd < 2; odd++) begin
        logic [47:0] pv;
        int p;
        p  = (sc == 1) ? 24 : (sc == 2) ? 22 : 23;
        pv = (48'(odd) << (p + 1)) | (48'd1 << p);
        wr(2'd3, 24'd0);
        vec("R7 clear", 3'd1, 1'b0, 1'b0, 2'd0, 2'd3, 2'd3, 2'd0, 1'b0, 1'b0, 2'd0, 24'd0);
        wr(2'd1, pv[47:24]); wr(2'd0, pv[23:0]);
        vec("R8 tie even", 3'd3, 1'b0, 1'b1, 2'(sc), 2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 2'd0, 24'd0);
        check("R8 tie value", acc_a, odd ? (56'd1 << (p + 2)) : 56'd0);
      end
    end

    // R9 logic on middle word, R11 rnd/sub ignored there
    wr(2'd0, 24'h0F0F0F);
    vec("R9 not", 3'd7, 1'b1, 1'b1, 2'd0, 2'd3, 2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 24'd0);
    vec("R9 and", 3'd4, 1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 24'd0);
    // R10 write to an operand in the same cycle it is used
    vec("R10 same-cycle", 3'd1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0, 24'h123456);
    // R11 idle
    vec("R11 nop", 3'd0, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 24'd0);

    // Constrained random mix (R3 R4 R6 R7 R9 R10 R11)
    void'($urandom(32'd4242));
    for (int n = 0; n < 2500; n++) begin
      logic [2:0] o;
      logic [1:0] sa, ws;
      logic [23:0] wd;
      o  = 3'($urandom_range(0, 7));
      sa = 2'($urandom_range(0, 3));
      ws = ($urandom_range(0, 2) == 0) ? sa : 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0:       wd = 24'h800000;
        1:       wd = 24'h7FFFFF;
        default: wd = 24'($urandom);
      endcase
      vec("R4 random", o, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          2'($urandom_range(0, 3)), sa, 2'($urandom_range(0, 3)),
          2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), ws, wd);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule